// File: doc/BRIEF.md
# Flag-Led Serial Hit Receiver

This block takes one single-wire serial hit line from each of a group of front-end chips. All lines are sampled on a fast clock that runs four times the bunch-crossing (BC) rate. A chip reports a hit by raising its line for one fast cycle (the flag). It then sends six address bits, most significant first, one per fast cycle. A frame is therefore seven fast cycles long and always spans a BC boundary. For each chip the block recovers the flag and the address and lines both up with the BC clock. Once per BC it presents a flag vector, an address-valid vector with one six-bit address per chip, and a per-chip error vector.

Flags are published at the first BC boundary after the BC in which they arrived, even though the address bits may still be coming in. Each address is published at the first BC boundary after its last bit has been stored. Depending on where the flag fell within its BC, that is one or two boundaries after the flag itself. A chip must stay quiet in the BC that follows one in which it flagged. The block treats a flag that breaks this rule as an error: it drops that flag and the six bits behind it, and reports the error for that chip.

The BC clock is an input that is phase-related to the fast clock. The block finds its rising edge by sampling it on the fast clock. The fast cycle in which the BC clock is first seen high opens a new BC.

Top module: `flag_hit_rx`

## Requirements
- R1: On an idle line a 1 is a flag. The next six line bits form the address, first bit = address bit 5, last bit = address bit 0.
- R2: A flag accepted in BC k sets its lane's bit in `hit_flags` from the boundary that closes BC k until the next boundary, for exactly one BC.
- R3: An address is driven on `addr_bus` lane slice [i*6 +: 6] with `addr_valid[i]` set for one BC, starting at the first BC boundary strictly after the fast cycle that delivered its last bit. If that last bit arrives in the opening cycle of a BC, the address waits for the following boundary.
- R4: Lanes are independent. Any mix of lanes and flag phases yields per-lane results with no crosstalk.
- R5: A flag arriving in the BC right after one in which the same lane flagged is ignored, together with the six bits behind it. The lane's `dead_err` bit is set for the one BC published at the same boundary as the flags of that BC, and `hit_flags` stays clear for that lane.
- R6: A lane flagging in BC k may flag again from BC k+2 onward, once its line is idle. It is accepted normally, with no error.
- R7: Synchronous active-high reset clears every lane's frame state, pending flags, pending addresses and all outputs. A frame cut off by reset produces no output.
- R8: The outputs change only at the fast-clock edge that closes the cycle in which a BC clock rising edge is detected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sampling clock, four cycles per BC |
| rst | input | 1 | Synchronous active-high reset |
| bc_clk | input | 1 | Bunch-crossing clock, phase-related to clk |
| ser_in | input | 32 | One serial hit line per chip |
| hit_flags | output | 32 | Lanes that flagged in the previous BC |
| addr_valid | output | 32 | Lanes whose address is presented this BC |
| addr_bus | output | 192 | Six-bit address per lane, lane i at [i*6 +: 6] |
| dead_err | output | 32 | Lanes that flagged inside their dead BC |

## Verification
The properties assume that `bc_clk` stays high for at least one fast cycle and low for at least one within each BC. They also assume it changes only between fast-clock edges, so that sampling it once per fast cycle finds every rising edge exactly once. The bench ties `bc_clk` to a cycle counter: high for two fast cycles and low for two. It drives it and the serial lines on the falling edge of `clk`, and it starts each frame sequence at the opening cycle of a BC, so every flag phase it chooses is known exactly. Serial lines never carry unknown values. The properties on repeated flags and errors hold for any line pattern, because the block enforces the dead BC itself.

// File: rtl/hitrx_pkg.sv
`timescale 1ns/1ps
package hitrx_pkg;

    localparam int HITRX_LANES  = 32;
    localparam int HITRX_ADDR_W = 6;

    // Lane frame state: waiting for a flag, shifting address bits,
    // or swallowing the bits behind a rejected flag.
    typedef enum logic [1:0] {
        LN_IDLE  = 2'd0,
        LN_SHIFT = 2'd1,
        LN_DROP  = 2'd2
    } lane_state_e;

    // One-cycle events a lane reports to its BC alignment slot.
    typedef struct packed {
        logic flag;   // flag accepted this cycle
        logic drop;   // flag rejected this cycle (dead BC)
        logic done;   // last address bit stored this cycle
    } lane_evt_t;

    // True when the bit counter points at the final address bit.
    function automatic logic is_last_bit(input int unsigned cnt, input int unsigned aw);
        return cnt == aw - 1;
    endfunction

endpackage

// File: rtl/hitrx_bc_edge.sv
`timescale 1ns/1ps
module hitrx_bc_edge (
    input  logic clk,
    input  logic rst,
    input  logic bc_clk,
    output logic bc_tick
);
    logic bc_q;

    always_ff @(posedge clk) begin
        if (rst) bc_q <= 1'b0;
        else     bc_q <= bc_clk;
    end

    // First fast cycle with the BC clock high opens a new BC.
    assign bc_tick = bc_clk & ~bc_q;
endmodule

// File: rtl/hitrx_lane.sv
`timescale 1ns/1ps
module hitrx_lane
    import hitrx_pkg::*;
#(
    parameter int AW = HITRX_ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ser,
    input  logic          block,
    output lane_evt_t     evt,
    output logic [AW-1:0] addr
);
    localparam int CW = (AW > 1) ? $clog2(AW) : 1;

    lane_state_e   st;
    logic [CW-1:0] cnt;
    logic [AW-2:0] sh;
    logic          last;

    assign last = is_last_bit(int'(cnt), AW);

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= LN_IDLE;
            cnt <= '0;
            sh  <= '0;
        end else begin
            unique case (st)
                LN_IDLE: begin
                    if (ser) begin
                        cnt <= '0;
                        st  <= block ? LN_DROP : LN_SHIFT;
                    end
                end
                LN_SHIFT: begin
                    sh <= {sh[AW-3:0], ser};
                    if (last) begin
                        st  <= LN_IDLE;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                LN_DROP: begin
                    if (last) begin
                        st  <= LN_IDLE;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: st <= LN_IDLE;
            endcase
        end
    end

    always_comb begin
        evt.flag = (st == LN_IDLE) && ser && !block;
        evt.drop = (st == LN_IDLE) && ser && block;
        evt.done = (st == LN_SHIFT) && last;
    end

    // Completed word: five stored bits plus the bit on the line now.
    assign addr = {sh, ser};
endmodule

// File: rtl/hitrx_slot.sv
`timescale 1ns/1ps
module hitrx_slot
    import hitrx_pkg::*;
#(
    parameter int AW = HITRX_ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bc_tick,
    input  lane_evt_t     evt,
    input  logic [AW-1:0] addr_in,
    output logic          block,
    output logic          flag_o,
    output logic          err_o,
    output logic          val_o,
    output logic [AW-1:0] addr_o
);
    logic          flag_pend;
    logic          err_pend;
    logic          rdy;
    logic [AW-1:0] hold;

    // Dead BC: the BC right after one in which this lane flagged.
    // In the opening cycle the pending flag is about to become "previous".
    assign block = bc_tick ? flag_pend : flag_o;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_pend <= 1'b0;
            err_pend  <= 1'b0;
            rdy       <= 1'b0;
            hold      <= '0;
            flag_o    <= 1'b0;
            err_o     <= 1'b0;
            val_o     <= 1'b0;
            addr_o    <= '0;
        end else begin
            if (evt.done) hold <= addr_in;
            if (bc_tick) begin
                flag_o    <= flag_pend;
                err_o     <= err_pend;
                val_o     <= rdy;
                addr_o    <= hold;
                flag_pend <= evt.flag;
                err_pend  <= evt.drop;
                rdy       <= evt.done;
            end else begin
                flag_pend <= flag_pend | evt.flag;
                err_pend  <= err_pend | evt.drop;
                rdy       <= rdy | evt.done;
            end
        end
    end
endmodule

// File: rtl/flag_hit_rx.sv
`timescale 1ns/1ps
module flag_hit_rx
    import hitrx_pkg::*;
#(
    parameter int NCH = HITRX_LANES,
    parameter int AW  = HITRX_ADDR_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            bc_clk,
    input  logic [NCH-1:0]  ser_in,
    output logic [NCH-1:0]  hit_flags,
    output logic [NCH-1:0]  addr_valid,
    output logic [NCH*AW-1:0] addr_bus,
    output logic [NCH-1:0]  dead_err
);
    logic bc_tick;

    hitrx_bc_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .bc_clk (bc_clk),
        .bc_tick(bc_tick)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_lane
        lane_evt_t     evt;
        logic [AW-1:0] word;
        logic          block;

        hitrx_lane #(.AW(AW)) u_lane (
            .clk  (clk),
            .rst  (rst),
            .ser  (ser_in[i]),
            .block(block),
            .evt  (evt),
            .addr (word)
        );

        hitrx_slot #(.AW(AW)) u_slot (
            .clk    (clk),
            .rst    (rst),
            .bc_tick(bc_tick),
            .evt    (evt),
            .addr_in(word),
            .block  (block),
            .flag_o (hit_flags[i]),
            .err_o  (dead_err[i]),
            .val_o  (addr_valid[i]),
            .addr_o (addr_bus[i*AW +: AW])
        );
    end
endmodule

// File: rtl/hitrx_checker.sv
`timescale 1ns/1ps
module hitrx_checker #(
    parameter int NCH = 32
) (
    input logic           clk,
    input logic           rst,
    input logic           bc_clk,
    input logic [NCH-1:0] hit_flags,
    input logic [NCH-1:0] addr_valid,
    input logic [NCH-1:0] dead_err
);
    logic bc_prev;
    logic bc_rise;

    always_ff @(posedge clk) begin
        if (rst) bc_prev <= 1'b0;
        else     bc_prev <= bc_clk;
    end
    assign bc_rise = bc_clk & ~bc_prev;

    // R8: outputs hold between BC boundaries
    p_quiet_between_r8: assert property (@(posedge clk) disable iff (rst)
        !bc_rise |=> ($stable(hit_flags) && $stable(addr_valid) && $stable(dead_err)));

    // R5: a lane never shows flags in two consecutive BCs
    p_no_repeat_flag_r5: assert property (@(posedge clk) disable iff (rst)
        bc_rise |=> ((hit_flags & $past(hit_flags)) == '0));

    // R5: an error only follows a BC in which the lane flagged
    p_err_after_flag_r5: assert property (@(posedge clk) disable iff (rst)
        bc_rise |=> ((dead_err & ~$past(hit_flags)) == '0));

    // R5: flag and error never shown together for one lane
    p_flag_err_excl_r5: assert property (@(posedge clk) disable iff (rst)
        ((hit_flags & dead_err) == '0));

    // R7: reset clears every output
    p_reset_clears_r7: assert property (@(posedge clk)
        rst |=> (hit_flags == '0 && addr_valid == '0 && dead_err == '0));
endmodule

bind flag_hit_rx hitrx_checker #(.NCH(NCH)) u_hitrx_chk (
    .clk       (clk),
    .rst       (rst),
    .bc_clk    (bc_clk),
    .hit_flags (hit_flags),
    .addr_valid(addr_valid),
    .dead_err  (dead_err)
);

// File: tb/test_flag_hit_rx.sv
`timescale 1ns/1ps
module test_flag_hit_rx;
    localparam int NCH = 32;
    localparam int AW  = 6;
    localparam int SL  = 64;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bc_clk = 1'b0;
    logic [NCH-1:0] ser_in = '0;
    logic [NCH-1:0] hit_flags, addr_valid, dead_err;
    logic [NCH*AW-1:0] addr_bus;

    flag_hit_rx #(.NCH(NCH), .AW(AW)) i_flag_hit_rx (
        .clk       (clk),
        .rst       (rst),
        .bc_clk    (bc_clk),
        .ser_in    (ser_in),
        .hit_flags (hit_flags),
        .addr_valid(addr_valid),
        .addr_bus  (addr_bus),
        .dead_err  (dead_err)
    );

    always #2.5 clk = ~clk;

    int total = 0;
    int bad   = 0;
    int gcyc  = 0;
    bit finished = 1'b0;

    logic [NCH-1:0]    seq    [SL];
    logic [NCH-1:0]    s_flag [SL];
    logic [NCH-1:0]    s_val  [SL];
    logic [NCH-1:0]    s_err  [SL];
    logic [NCH*AW-1:0] s_addr [SL];

    // {lane mask[31:0], flag phase[1:0], address base[5:0]}
    localparam logic [39:0] VEC [6] = '{
        {32'h0000_0001, 2'd0, 6'h2A},
        {32'h8000_0000, 2'd3, 6'h15},
        {32'hFFFF_FFFF, 2'd1, 6'h00},
        {32'hAAAA_5555, 2'd2, 6'h3F},
        {32'h0000_F00F, 2'd3, 6'h11},
        {32'h0000_0000, 2'd0, 6'h00}
    };

    task automatic step(input logic [NCH-1:0] v);
        ser_in = v;
        bc_clk = ((gcyc % 4) < 2);
        @(negedge clk);
        gcyc++;
    endtask

    task automatic align();
        while ((gcyc % 4) != 0) step('0);
    endtask

    task automatic clear_seq();
        for (int c = 0; c < SL; c++) seq[c] = '0;
    endtask

    task automatic put_frame(input int ch, input int st, input logic [AW-1:0] a);
        seq[st][ch] = 1'b1;
        for (int k = 0; k < AW; k++) seq[st + 1 + k][ch] = a[AW-1-k];
    endtask

    // Sample before driving cycle c: sample c shows edges up to end of cycle c-1.
    task automatic run_seq(input int n);
        align();
        for (int c = 0; c < n; c++) begin
            s_flag[c] = hit_flags;
            s_val[c]  = addr_valid;
            s_err[c]  = dead_err;
            s_addr[c] = addr_bus;
            step(seq[c]);
        end
    endtask

    task automatic chk_v(input string req, input string what,
                         input logic [NCH-1:0] got, input logic [NCH-1:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic chk_a(input string req, input logic [NCH*AW-1:0] got,
                         input logic [NCH*AW-1:0] exp, input logic [NCH-1:0] m);
        logic [NCH*AW-1:0] msk;
        msk = '0;
        for (int i = 0; i < NCH; i++) if (m[i]) msk[i*AW +: AW] = '1;
        total++;
        if ((got & msk) !== (exp & msk)) begin
            bad++;
            $display("FAIL %s address: actual %h expected %h", req, got & msk, exp & msk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [NCH-1:0]    mask;
        logic [1:0]        ph;
        logic [AW-1:0]     base;
        logic [NCH*AW-1:0] exp_bus;
        logic [NCH-1:0]    acc;

        // R7: outputs during and after reset
        rst = 1'b1;
        repeat (5) step('0);
        chk_v("R7", "flags in reset", hit_flags, '0);
        chk_v("R7", "valid in reset", addr_valid | dead_err, '0);
        rst = 1'b0;
        align();
        repeat (8) step('0);
        chk_v("R7", "idle after reset", hit_flags | addr_valid | dead_err, '0);

        // R1 R2 R3 R4: vector table
        for (int v = 0; v < 6; v++) begin
            mask = VEC[v][39:8];
            ph   = VEC[v][7:6];
            base = VEC[v][5:0];
            clear_seq();
            exp_bus = '0;
            for (int i = 0; i < NCH; i++) begin
                exp_bus[i*AW +: AW] = base + AW'(i);
                if (mask[i]) put_frame(i, int'(ph), base + AW'(i));
            end
            run_seq(24);
            chk_v("R2", "flags one BC later", s_flag[6], mask);
            chk_v("R2", "flags clear next BC", s_flag[10] | s_flag[14], '0);
            chk_v("R3", "valid first boundary", s_val[10], (ph < 2) ? mask : '0);
            chk_v("R3", "valid second boundary", s_val[14], (ph >= 2) ? mask : '0);
            chk_a("R1", (ph < 2) ? s_addr[10] : s_addr[14], exp_bus, mask);
            chk_v("R4", "no errors or leftovers", s_err[6] | s_err[10] | s_err[14] | s_val[6] | s_val[18] | s_flag[18], '0);
        end

        // R5: flag in the dead BC is dropped with its bits
        clear_seq();
        put_frame(3, 0, 6'h2D);
        put_frame(3, 7, 6'h3F);
        put_frame(3, 16, 6'h07);
        run_seq(32);
        chk_v("R5", "first flag", s_flag[6], 32'h8);
        chk_v("R5", "error flagged", s_err[10], 32'h8);
        chk_v("R5", "dead flag hidden", s_flag[10], '0);
        chk_v("R5", "first address valid", s_val[10], 32'h8);
        exp_bus = '0;
        exp_bus[3*AW +: AW] = 6'h2D;
        chk_a("R5", s_addr[10], exp_bus, 32'h8);
        chk_v("R5", "dropped bits unseen", s_flag[14] | s_val[14] | s_err[14] | s_flag[18] | s_val[18], '0);
        chk_v("R5", "recovery flag", s_flag[22], 32'h8);
        chk_v("R5", "recovery valid", s_val[26], 32'h8);
        exp_bus[3*AW +: AW] = 6'h07;
        chk_a("R5", s_addr[26], exp_bus, 32'h8);

        // R6: flag two BCs later accepted
        clear_seq();
        put_frame(5, 3, 6'h15);
        put_frame(5, 10, 6'h2A);
        run_seq(32);
        chk_v("R6", "flags BC0 and BC2", s_flag[6] | s_flag[14], 32'h20);
        chk_v("R6", "no flag BC1", s_flag[10], '0);
        chk_v("R6", "valid first", s_val[14], 32'h20);
        exp_bus = '0;
        exp_bus[5*AW +: AW] = 6'h15;
        chk_a("R6", s_addr[14], exp_bus, 32'h20);
        chk_v("R6", "valid second", s_val[22], 32'h20);
        exp_bus[5*AW +: AW] = 6'h2A;
        chk_a("R6", s_addr[22], exp_bus, 32'h20);
        chk_v("R6", "no errors", s_err[10] | s_err[14] | s_err[18] | s_err[22], '0);

        // R7: reset cuts a frame in flight
        clear_seq();
        put_frame(9, 1, 6'h3F);
        align();
        for (int c = 0; c < 6; c++) step(seq[c]);
        chk_v("R7", "flag before reset", hit_flags, 32'h200);
        rst = 1'b1;
        repeat (3) step('0);
        rst = 1'b0;
        acc = '0;
        for (int c = 0; c < 24; c++) begin
            acc = acc | hit_flags | addr_valid | dead_err;
            step('0);
        end
        chk_v("R7", "nothing after cut frame", acc, '0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule